// File: doc/BRIEF.md
# Latched End-of-Discharge Cutoff Controller

This block decides whether a battery stack may keep feeding its load when no charging source is present. While the DC source is valid the load path is held on unconditionally. Once the DC source is gone, each cell's under-voltage comparator flag is watched. A flag that stays set across a run of consecutive 1 ms samples opens the internal load switch, pulls the external FET drive low and asks the rest of the chip to drop into standby.

The cutoff is latched. It clears only when the DC source returns, which also starts a new charge cycle, or when a cell-replacement event is reported. A cell-count select can leave the last cell out of the decision for three-cell stacks.

A three-level select pin (high, floating, ground) chooses the cutoff voltage. The block decodes it to a 2-bit code that it publishes for the analog threshold generator. The code is captured once after reset and again each time DC reconnects, and is held between those captures.

Top module: `eod_cutoff_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `load_en` = 1, `ext_drv` = 1 and `standby_req` = 0.
- R2: With `dc_ok` = 1 at a clock edge, `load_en` and `ext_drv` are 1 after that edge, whatever the cell flags say, and any latched cutoff is released.
- R3: With `dc_ok` = 0, a cell flag that reads 1 on `TRIP_TICKS` consecutive sample ticks (one tick every `TICK_DIV` clocks) trips the cutoff. `load_en` = 0, `ext_drv` = 0 and `standby_req` = 1 from the clock edge after the tick that completes the run.
- R4: A sample tick on which a cell flag reads 0 restarts that cell's run, so a flag that is never set for `TRIP_TICKS` ticks in a row does not trip.
- R5: Once tripped, the outputs stay off and `standby_req` stays 1 while `dc_ok` = 0 and `cells_swapped` = 0, even after every flag clears.
- R6: A one-cycle `cells_swapped` pulse releases a tripped cutoff at the next edge and restarts all runs, so a flag still set needs a fresh run of `TRIP_TICKS` ticks to trip again.
- R7: With `four_cell_mode` = 0, flag bit `NCELL-1` (bit 3 by default) is ignored. With `four_cell_mode` = 1 it counts like the others.
- R8: `cut_code` decodes `thr_pin` as 2'b10 (pin tied high) to 2'b10 (1.10 V), 2'b01 (floating) to 2'b01 (1.00 V) and 2'b00 (tied to ground) to 2'b00 (0.90 V). The unused pin reading 2'b11 maps to 2'b01. `cut_code` is never 2'b11. Its reset value is 2'b01.
- R9: `cut_code` is loaded from `thr_pin` at the first edge after reset and at each edge where `dc_ok` is 1 after being 0 on the previous edge. It holds its value at all other times.
- R10: `ext_drv` is never 1 while `load_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dc_ok | input | 1 | Charging source is valid (above stack top) |
| cells_swapped | input | 1 | One-cycle pulse: cells were replaced |
| cell_low | input | NCELL | Per-cell under-voltage comparator flags |
| four_cell_mode | input | 1 | 1 = all cells used; 0 = last cell ignored |
| thr_pin | input | 2 | Three-level select pin reading: 10 high, 01 floating, 00 ground |
| load_en | output | 1 | Internal load-switch enable |
| ext_drv | output | 1 | External N-FET gate drive |
| standby_req | output | 1 | Low-power standby request after cutoff |
| cut_code | output | 2 | Selected cutoff code for the analog threshold |

## Verification
Steady low flags and flags that drop out for one tick in every three are both applied, which tells a true consecutive-run filter apart from one that counts total lows. The last cell's flag is driven alone in both cell-count modes, which shows whether the mode gates exactly that bit. A trip is released once by a swap pulse with the flags still set and once by a DC return, which separates a release that restarts the runs from one that leaves stale counts. The select pin is changed while DC stays absent and then across DC reconnects, including the unused reading, which shows that the code is captured only at those edges and never takes the invalid value.

// File: rtl/eod_pkg.sv
package eod_pkg;

  typedef enum logic [1:0] {
    CUT_090 = 2'b00,
    CUT_100 = 2'b01,
    CUT_110 = 2'b10
  } cut_code_e;

  typedef enum logic {
    ST_ON  = 1'b0,
    ST_OFF = 1'b1
  } ctl_state_e;

  // Pin reading: 2'b10 tied high, 2'b01 floating, 2'b00 grounded.
  // The unused reading 2'b11 is treated as the middle level.
  function automatic cut_code_e decode_thr(input logic [1:0] pin);
    cut_code_e code;
    case (pin)
      2'b10:   code = CUT_110;
      2'b00:   code = CUT_090;
      default: code = CUT_100;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/eod_tick_gen.sv
module eod_tick_gen #(
  parameter int TICK_DIV = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/eod_cell_filter.sv
module eod_cell_filter #(
  parameter int TRIP_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic low,
  output logic tripped
);
  localparam int RW = $clog2(TRIP_TICKS + 1);
  localparam logic [RW-1:0] FULL = RW'(TRIP_TICKS);

  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run <= '0;
    end else if (tick) begin
      if (low) begin
        if (run != FULL) run <= run + 1'b1;
      end else begin
        run <= '0;
      end
    end
  end

  assign tripped = (run == FULL);
endmodule

// File: rtl/eod_thr_latch.sv
module eod_thr_latch
  import eod_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dc_ok,
  input  logic [1:0] thr_pin,
  output cut_code_e  code
);
  logic pend;
  logic dc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= CUT_100;
      pend <= 1'b1;
      dc_q <= 1'b0;
    end else begin
      dc_q <= dc_ok;
      if (pend || (dc_ok && !dc_q)) begin
        code <= decode_thr(thr_pin);
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/eod_cutoff_fsm.sv
module eod_cutoff_fsm
  import eod_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dc_ok,
  input  logic swapped,
  input  logic trip_any,
  output logic monitor,
  output logic load_en,
  output logic ext_drv,
  output logic standby_req
);
  ctl_state_e state, nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_ON:   if (!dc_ok && !swapped && trip_any) nxt = ST_OFF;
      ST_OFF:  if (dc_ok || swapped) nxt = ST_ON;
      default: nxt = ST_ON;
    endcase
  end

  assign monitor = (state == ST_ON) && !dc_ok && !swapped;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_ON;
      load_en     <= 1'b1;
      ext_drv     <= 1'b1;
      standby_req <= 1'b0;
    end else begin
      state       <= nxt;
      load_en     <= (nxt == ST_ON);
      ext_drv     <= (nxt == ST_ON);
      standby_req <= (nxt == ST_OFF);
    end
  end
endmodule

// File: rtl/eod_cutoff_ctrl.sv
module eod_cutoff_ctrl
  import eod_pkg::*;
#(
  parameter int NCELL      = 4,
  parameter int TICK_DIV   = 50000,
  parameter int TRIP_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dc_ok,
  input  logic             cells_swapped,
  input  logic [NCELL-1:0] cell_low,
  input  logic             four_cell_mode,
  input  logic [1:0]       thr_pin,
  output logic             load_en,
  output logic             ext_drv,
  output logic             standby_req,
  output logic [1:0]       cut_code
);
  logic             tick;
  logic             monitor;
  logic [NCELL-1:0] tripped;
  cut_code_e        code;

  eod_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic used;
    if (i == NCELL - 1) begin : g_last
      assign used = four_cell_mode;
    end else begin : g_fixed
      assign used = 1'b1;
    end

    eod_cell_filter #(.TRIP_TICKS(TRIP_TICKS)) u_filt (
      .clk     (clk),
      .rst     (rst),
      .clr     (!monitor),
      .tick    (tick),
      .low     (cell_low[i] && used),
      .tripped (tripped[i])
    );
  end

  eod_cutoff_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .dc_ok       (dc_ok),
    .swapped     (cells_swapped),
    .trip_any    (|tripped),
    .monitor     (monitor),
    .load_en     (load_en),
    .ext_drv     (ext_drv),
    .standby_req (standby_req)
  );

  eod_thr_latch u_thr (
    .clk     (clk),
    .rst     (rst),
    .dc_ok   (dc_ok),
    .thr_pin (thr_pin),
    .code    (code)
  );

  assign cut_code = code;
endmodule

// File: rtl/eod_cutoff_ctrl_chk.sv
module eod_cutoff_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       dc_ok,
  input logic       cells_swapped,
  input logic       load_en,
  input logic       ext_drv,
  input logic       standby_req,
  input logic [1:0] cut_code
);
  logic armed;
  logic dc_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      dc_seen <= 1'b0;
    end else begin
      armed   <= 1'b1;
      dc_seen <= dc_ok;
    end
  end

  // R10
  p_drv_needs_load_r10: assert property (@(posedge clk) disable iff (rst)
    ext_drv |-> load_en);

  // R2
  p_dc_holds_on_r2: assert property (@(posedge clk) disable iff (rst)
    dc_ok |=> (load_en && ext_drv && !standby_req));

  // R5
  p_cut_latched_r5: assert property (@(posedge clk) disable iff (rst)
    (standby_req && !dc_ok && !cells_swapped) |=> (standby_req && !load_en));

  // R6
  p_swap_release_r6: assert property (@(posedge clk) disable iff (rst)
    (standby_req && cells_swapped) |=> load_en);

  // R3
  p_trip_only_unpowered_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(load_en) |-> $past(!dc_ok && !cells_swapped));

  // R8
  p_code_valid_r8: assert property (@(posedge clk) disable iff (rst)
    cut_code != 2'b11);

  // R9
  p_code_held_r9: assert property (@(posedge clk) disable iff (rst)
    (armed && !(dc_ok && !dc_seen)) |=> $stable(cut_code));
endmodule

bind eod_cutoff_ctrl eod_cutoff_ctrl_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .dc_ok         (dc_ok),
  .cells_swapped (cells_swapped),
  .load_en       (load_en),
  .ext_drv       (ext_drv),
  .standby_req   (standby_req),
  .cut_code      (cut_code)
);

// File: tb/tb_eod_cutoff_ctrl.sv
`timescale 1ns/1ps
module tb_eod_cutoff_ctrl;
  localparam int NC  = 4;
  localparam int DIV = 8;
  localparam int RUN = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dc_ok = 1'b0;
  logic          cells_swapped = 1'b0;
  logic [NC-1:0] cell_low = '0;
  logic          four_cell_mode = 1'b1;
  logic [1:0]    thr_pin = 2'b10;
  logic          load_en, ext_drv, standby_req;
  logic [1:0]    cut_code;

  int    errs = 0;
  int    checks = 0;
  bit    done = 0;
  bit    cmp_on = 0;
  string ph = "R1";

  always #10 clk = ~clk;

  eod_cutoff_ctrl #(.NCELL(NC), .TICK_DIV(DIV), .TRIP_TICKS(RUN)) dut (
    .clk(clk), .rst(rst), .dc_ok(dc_ok), .cells_swapped(cells_swapped),
    .cell_low(cell_low), .four_cell_mode(four_cell_mode), .thr_pin(thr_pin),
    .load_en(load_en), .ext_drv(ext_drv), .standby_req(standby_req),
    .cut_code(cut_code));

  // behavioural reference
  int       m_phase = 0;
  bit       m_tick = 0;
  int       m_low_streak [NC];
  bit       m_off = 0;
  bit [1:0] m_code = 2'b01;
  bit       m_first = 1;
  bit       m_dc_prev = 0;

  function automatic bit [1:0] want_code(input logic [1:0] p);
    if (p == 2'b10) return 2'b10;
    if (p == 2'b00) return 2'b00;
    return 2'b01;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_tick = 0; m_off = 0; m_code = 2'b01;
      m_first = 1; m_dc_prev = 0;
      for (int i = 0; i < NC; i++) m_low_streak[i] = 0;
    end else begin
      bit any_full, watching;
      any_full = 0;
      for (int i = 0; i < NC; i++) if (m_low_streak[i] >= RUN) any_full = 1;
      watching = !m_off && !dc_ok && !cells_swapped;
      for (int i = 0; i < NC; i++) begin
        bit counted;
        counted = cell_low[i] && (i != NC-1 || four_cell_mode);
        if (!watching) m_low_streak[i] = 0;
        else if (m_tick) m_low_streak[i] = counted ? m_low_streak[i] + 1 : 0;
      end
      if (m_off) m_off = !(dc_ok || cells_swapped);
      else       m_off = !dc_ok && !cells_swapped && any_full;
      m_tick  = (m_phase == DIV-1);
      m_phase = (m_phase == DIV-1) ? 0 : m_phase + 1;
      if (m_first || (dc_ok && !m_dc_prev)) begin
        m_code  = want_code(thr_pin);
        m_first = 0;
      end
      m_dc_prev = dc_ok;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(ph, "load_en", {1'b0, load_en}, {1'b0, !m_off});
      chk(ph, "ext_drv", {1'b0, ext_drv}, {1'b0, !m_off});
      chk(ph, "standby_req", {1'b0, standby_req}, {1'b0, m_off});
      chk(ph, "cut_code", cut_code, m_code);
      if (ext_drv && !load_en) chk("R10", "drv_without_load", 2'd1, 2'd0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    cmp_on = 1;
    cyc(4);
    chk("R1", "reset_load", {1'b0, load_en}, 2'd1);
    chk("R1", "reset_standby", {1'b0, standby_req}, 2'd0);
    rst = 1'b0;
    cyc(1);
    chk("R1", "post_reset_load", {1'b0, load_en}, 2'd1);
    chk("R9", "first_capture", cut_code, 2'b10);

    ph = "R3"; cell_low = 4'b0001; cyc(6*DIV);
    chk("R3", "trip_load", {1'b0, load_en}, 2'd0);
    chk("R3", "trip_standby", {1'b0, standby_req}, 2'd1);

    ph = "R5"; cell_low = '0; thr_pin = 2'b00; cyc(3*DIV);
    chk("R5", "held_off", {1'b0, load_en}, 2'd0);
    chk("R9", "no_capture_without_dc", cut_code, 2'b10);

    ph = "R2"; dc_ok = 1'b1; cyc(2);
    chk("R2", "dc_release", {1'b0, ext_drv}, 2'd1);
    chk("R8", "ground_code", cut_code, 2'b00);
    cell_low = 4'b1111; cyc(6*DIV);
    chk("R2", "dc_ignores_low", {1'b0, load_en}, 2'd1);
    dc_ok = 1'b0; cell_low = '0; cyc(2*DIV);

    ph = "R4";
    for (int k = 0; k < 4; k++) begin
      cell_low = 4'b0100; cyc(2*DIV);
      cell_low = '0;      cyc(DIV);
    end
    chk("R4", "broken_runs", {1'b0, load_en}, 2'd1);

    ph = "R7"; four_cell_mode = 1'b0; cell_low = 4'b1000; cyc(6*DIV);
    chk("R7", "last_cell_ignored", {1'b0, load_en}, 2'd1);
    four_cell_mode = 1'b1; cyc(6*DIV);
    chk("R7", "last_cell_used", {1'b0, load_en}, 2'd0);

    ph = "R6"; cells_swapped = 1'b1; cyc(1); cells_swapped = 1'b0;
    chk("R6", "swap_release", {1'b0, load_en}, 2'd1);
    cyc(2*DIV);
    chk("R6", "fresh_run_needed", {1'b0, load_en}, 2'd1);
    cyc(4*DIV);
    chk("R6", "retrip_after_swap", {1'b0, load_en}, 2'd0);
    cell_low = '0; cells_swapped = 1'b1; cyc(1); cells_swapped = 1'b0; cyc(DIV);

    ph = "R8"; thr_pin = 2'b01; dc_ok = 1'b1; cyc(2);
    chk("R8", "float_code", cut_code, 2'b01);
    dc_ok = 1'b0; thr_pin = 2'b10; cyc(3);
    dc_ok = 1'b1; cyc(2);
    chk("R8", "high_code", cut_code, 2'b10);
    dc_ok = 1'b0; thr_pin = 2'b11; cyc(3);
    dc_ok = 1'b1; cyc(2);
    chk("R8", "unused_reading", cut_code, 2'b01);
    thr_pin = 2'b00; cyc(5);
    chk("R9", "held_while_dc", cut_code, 2'b01);
    dc_ok = 1'b0; cyc(DIV);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule